// File: doc/BRIEF.md
# Low-Speed USB Oversampling Receiver

This block recovers low-speed USB packets from the D+/D- pair. It has no recovered bit clock. One free-running system clock runs at about eleven times the bit rate, and a counter inside the block decides when each bit is taken. While the bus is idle the block waits for a J-to-K transition. It then hunts through the sync field, and it starts the packet body once two bit-centre samples in a row read K.

After that point it realigns its sample point on every line transition, so it stays locked when the bit period drifts by about one percent. It turns the line levels back into data bits and drops the bits inserted by bit stuffing. It assembles bytes least-significant bit first and presents each byte with a one-cycle strobe. An SE0 seen at a sample point ends the packet, and the block then reports how many complete bytes arrived.

The receive buffer has a fixed size. A byte beyond that size raises an overflow and aborts the packet. A K glitch that is not followed by a valid sync ends in a timeout and a sync-error pulse.

The inputs are D+/D- levels that have already been synchronized. Packet parsing, CRC checking and the analog front end belong to other blocks.

Top module: `usb_ls_rx`

## Requirements
- R1: The line levels are decoded as J (`line_dp`=0, `line_dm`=1), K (`line_dp`=1, `line_dm`=0) and SE0 (both 0). The bus idles in J. A packet can start only on a transition from J to K.
- R2: The block takes a bit-centre sample SAMPLE_OFS (5) clocks after each detected line transition, then one every CLKS_PER_BIT (11) clocks. The packet body begins after two consecutive K samples.
- R3: During the sync hunt, a K sample followed by a sample that is not K does not end the sync. Hunting continues, so a preamble with extra K/J pairs before the final K K still decodes correctly.
- R4: The sync timeout is SYNC_TMO_BITS×CLKS_PER_BIT clocks (33). If no line transition occurs for that long while hunting, `rx_sync_err` pulses for one cycle and the block returns to idle without reporting any byte or end of packet.
- R5: The sample point is realigned on every transition. Packets whose bit period is stretched or shortened by one clock on every ninth bit (about ±1%) decode without error.
- R6: The line code is NRZI. A bit is 1 when the line level equals the level at the previous sample and 0 when it changed. The final K of the sync is the reference for the first data bit.
- R7: The bit after six consecutive decoded 1s is a stuffed bit and is discarded. The final sync bit counts as the first 1 of that run.
- R8: Bytes are assembled least-significant bit first. `rx_byte_vld` pulses for one cycle after every eighth kept bit, and `rx_byte` holds that byte in the same cycle.
- R9: An SE0 at a sample point during the packet body pulses `rx_eop` for one cycle. `rx_count` then holds the number of complete bytes. Bits of an unfinished byte are discarded, and a packet with no data bytes reports 0.
- R10: When a packet carries more than BUF_BYTES bytes, the first byte beyond the limit is not delivered. Instead, `rx_overflow` pulses once and no `rx_eop` follows. The rest of the packet is ignored until SE0, and the next packet is received normally.
- R11: During and directly after reset, every output is 0.
- R12: At most one of `rx_byte_vld`, `rx_eop`, `rx_overflow` and `rx_sync_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 11× the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_dp | input | 1 | Synchronized D+ level |
| line_dm | input | 1 | Synchronized D- level |
| rx_byte_vld | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte, valid with the strobe |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_count | output | $clog2(BUF_BYTES+1) | Number of bytes in the packet, valid with `rx_eop` |
| rx_overflow | output | 1 | One-cycle pulse when the buffer limit is exceeded |
| rx_sync_err | output | 1 | One-cycle pulse when the sync hunt times out |

## Verification
The hardest case to reach is a sample point that must keep up with a drifting bit clock while stuffed bits sit next to byte boundaries. In that case a sample taken one clock off would flip a decoded bit or misplace a stuffing drop. The driver produces this by encoding every packet itself. It applies NRZI and stuffing starting from the sync's final 1, and it makes every ninth bit one clock longer or shorter, using runs of 0xFF that force stuffed bits across byte edges. Other packets reach the two exits from sync: an extra K/J preamble that must not end the hunt, and a lone K pulse that must time out. Packets at, and one byte over, the buffer size exercise the overflow path and the recovery that follows it.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_RECV  = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/usb_ls_rx_dpll.sv
module usb_ls_rx_dpll #(
  parameter int unsigned CLKS_PER_BIT = 11,
  parameter int unsigned SAMPLE_OFS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_dp,
  input  logic line_dm,
  output logic edge_o,
  output logic to_k_o,
  output logic sample_o
);

  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_SMP  = CW'(SAMPLE_OFS);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          jk;

  // Differential level present (J or K), and it differs from the last one seen.
  assign jk       = line_dp ^ line_dm;
  assign edge_o   = jk && (line_dm != lvl_q);
  assign to_k_o   = edge_o && !line_dm;
  assign sample_o = !edge_o && (cnt_q == CNT_SMP);

  always_comb begin
    lvl_d = jk ? line_dm : lvl_q;
    if (edge_o) begin
      cnt_d = CNT_ONE;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  AST_EDGE_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (cnt_q == CNT_ONE)) else $error("edge did not realign phase"); // R5

endmodule

// File: rtl/usb_ls_rx_unstuff.sv
module usb_ls_rx_unstuff #(
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic smp_i,
  input  logic line_dm,
  output logic bit_vld_o,
  output logic bit_val_o
);

  localparam int unsigned RW = $clog2(STUFF_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);
  localparam logic [RW-1:0] RUN_ONE = RW'(1);

  logic          prev_q, prev_d;
  logic [RW-1:0] ones_q, ones_d;
  logic          stuffed;

  assign bit_val_o = (line_dm == prev_q);
  assign stuffed   = (ones_q == RUN_MAX);
  assign bit_vld_o = smp_i && !stuffed;

  always_comb begin
    prev_d = prev_q;
    ones_d = ones_q;
    if (start_i) begin
      prev_d = 1'b0;      // final sync level is K (D- low)
      ones_d = RUN_ONE;   // final sync bit is a decoded 1
    end else if (smp_i) begin
      prev_d = line_dm;
      if (stuffed) begin
        ones_d = '0;
      end else if (bit_val_o) begin
        ones_d = ones_q + RUN_ONE;
      end else begin
        ones_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ones_q <= '0;
    end else begin
      prev_q <= prev_d;
      ones_q <= ones_d;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_MAX) else $error("ones run beyond stuffing limit"); // R7

endmodule

// File: rtl/usb_ls_rx_pack.sv
module usb_ls_rx_pack
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 11,
  localparam int unsigned NW = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              se0_end_i,
  output logic              ovf_hit_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              eop_o,
  output logic [NW-1:0]     count_o,
  output logic              ovf_o
);

  localparam logic [NW-1:0] NB_MAX = NW'(BUF_BYTES);
  localparam logic [NW-1:0] NB_ONE = NW'(1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [2:0]        bitcnt_q, bitcnt_d;
  logic [NW-1:0]     nb_q, nb_d;
  logic              full;
  logic [BYTE_W-1:0] next_byte;

  logic              vld_q;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              eop_q;
  logic [NW-1:0]     cnt_q, cnt_d;
  logic              ovf_q;

  assign next_byte = {bit_val_i, sh_q[BYTE_W-1:1]};
  assign full      = bit_vld_i && (bitcnt_q == 3'd7);
  assign ovf_hit_o = full && (nb_q == NB_MAX);

  always_comb begin
    sh_d     = sh_q;
    bitcnt_d = bitcnt_q;
    nb_d     = nb_q;
    if (start_i) begin
      bitcnt_d = '0;
      nb_d     = '0;
    end else if (bit_vld_i) begin
      sh_d     = next_byte;
      bitcnt_d = bitcnt_q + 3'd1;
      if (full && !ovf_hit_o) begin
        nb_d = nb_q + NB_ONE;
      end
    end
    byte_d = (full && !ovf_hit_o) ? next_byte : byte_q;
    cnt_d  = se0_end_i ? nb_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bitcnt_q <= '0;
      nb_q     <= '0;
      vld_q    <= 1'b0;
      byte_q   <= '0;
      eop_q    <= 1'b0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      bitcnt_q <= bitcnt_d;
      nb_q     <= nb_d;
      vld_q    <= full && !ovf_hit_o;
      byte_q   <= byte_d;
      eop_q    <= se0_end_i;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_hit_o;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign eop_o      = eop_q;
  assign count_o    = cnt_q;
  assign ovf_o      = ovf_q;

  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (nb_q == NB_MAX)) else $error("overflow below buffer limit"); // R10

  AST_EOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> (count_o <= NB_MAX)) else $error("count beyond buffer"); // R9

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT  = 11,
  parameter int unsigned SAMPLE_OFS    = 5,
  parameter int unsigned BUF_BYTES     = 11,
  parameter int unsigned STUFF_RUN     = 6,
  parameter int unsigned SYNC_TMO_BITS = 3,
  localparam int unsigned NW = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic              rx_byte_vld,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_eop,
  output logic [NW-1:0]     rx_count,
  output logic              rx_overflow,
  output logic              rx_sync_err
);

  localparam int unsigned TMO = SYNC_TMO_BITS * CLKS_PER_BIT;
  localparam int unsigned TW  = $clog2(TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO - 1);

  rx_state_e     state_q, state_d;
  logic          k_q, k_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          serr_q, serr_d;

  logic edge_w, to_k_w, sample_w;
  logic start_w, smp_rx_w, se0_end_w, ovf_hit_w;
  logic bit_vld_w, bit_val_w;
  logic is_k, is_se0, is_jk;

  assign is_k   = line_dp && !line_dm;
  assign is_se0 = !line_dp && !line_dm;
  assign is_jk  = line_dp ^ line_dm;

  usb_ls_rx_dpll #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .SAMPLE_OFS  (SAMPLE_OFS)
  ) u_dpll (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_dp (line_dp),
    .line_dm (line_dm),
    .edge_o  (edge_w),
    .to_k_o  (to_k_w),
    .sample_o(sample_w)
  );

  usb_ls_rx_unstuff #(
    .STUFF_RUN(STUFF_RUN)
  ) u_unstuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .smp_i    (smp_rx_w),
    .line_dm  (line_dm),
    .bit_vld_o(bit_vld_w),
    .bit_val_o(bit_val_w)
  );

  usb_ls_rx_pack #(
    .BUF_BYTES(BUF_BYTES)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .bit_vld_i (bit_vld_w),
    .bit_val_i (bit_val_w),
    .se0_end_i (se0_end_w),
    .ovf_hit_o (ovf_hit_w),
    .byte_vld_o(rx_byte_vld),
    .byte_o    (rx_byte),
    .eop_o     (rx_eop),
    .count_o   (rx_count),
    .ovf_o     (rx_overflow)
  );

  always_comb begin
    state_d   = state_q;
    k_d       = k_q;
    tmo_d     = tmo_q;
    serr_d    = 1'b0;
    start_w   = 1'b0;
    smp_rx_w  = 1'b0;
    se0_end_w = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (to_k_w) begin
          state_d = ST_HUNT;
          k_d     = 1'b0;
          tmo_d   = '0;
        end
      end
      ST_HUNT: begin
        tmo_d = edge_w ? '0 : tmo_q + TW'(1);
        if (sample_w) begin
          k_d = is_k;
          if (is_k && k_q) begin
            state_d = ST_RECV;
            start_w = 1'b1;
          end
        end
        if (!edge_w && (tmo_q == TMO_LAST)) begin
          state_d = ST_IDLE;
          serr_d  = 1'b1;
          start_w = 1'b0;
        end
      end
      ST_RECV: begin
        if (sample_w) begin
          if (is_se0) begin
            se0_end_w = 1'b1;
            state_d   = ST_IDLE;
          end else if (is_jk) begin
            smp_rx_w = 1'b1;
          end
        end
        if (ovf_hit_w) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (is_se0) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= 1'b0;
      tmo_q   <= '0;
      serr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
      tmo_q   <= tmo_d;
      serr_q  <= serr_d;
    end
  end

  assign rx_sync_err = serr_q;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_byte_vld, rx_eop, rx_overflow, rx_sync_err})) else $error("events overlap"); // R12

  AST_SYNCERR_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync_err |-> ($past(state_q) == ST_HUNT)) else $error("sync error outside hunt"); // R4

  AST_START_ON_K: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && state_d == ST_HUNT) |-> (line_dp && !line_dm)) else $error("start not on K"); // R1

  AST_BODY_AFTER_KK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && state_d == ST_RECV) |-> (k_q && is_k)) else $error("body without two K"); // R2

endmodule

// File: tb/usb_ls_rx_tb.sv
module usb_ls_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 11;
  localparam int BUF        = 4;
  localparam int NW         = $clog2(BUF + 1);

  localparam int EV_BYTE = 0;
  localparam int EV_EOP  = 1;
  localparam int EV_OVF  = 2;
  localparam int EV_SERR = 3;

  localparam int LV_J   = 0;
  localparam int LV_K   = 1;
  localparam int LV_SE0 = 2;

  typedef struct {
    int    kind;
    int    val;
    string tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          line_dp;
  logic          line_dm;
  logic          rx_byte_vld;
  logic [7:0]    rx_byte;
  logic          rx_eop;
  logic [NW-1:0] rx_count;
  logic          rx_overflow;
  logic          rx_sync_err;

  int   checks;
  int   errors;
  exp_t expq[$];
  logic [7:0] pkt[$];
  int   stretch_every;
  int   stretch_delta;
  int   bitno;
  bit   done;

  usb_ls_rx #(
    .BUF_BYTES(BUF)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_dp    (line_dp),
    .line_dm    (line_dm),
    .rx_byte_vld(rx_byte_vld),
    .rx_byte    (rx_byte),
    .rx_eop     (rx_eop),
    .rx_count   (rx_count),
    .rx_overflow(rx_overflow),
    .rx_sync_err(rx_sync_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int val, input string tag);
    exp_t e;
    e.kind = kind;
    e.val  = val;
    e.tag  = tag;
    expq.push_back(e);
  endtask

  task automatic got_ev(input int kind, input int val);
    exp_t e;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected event R12", kind, -1);
    end else begin
      e = expq.pop_front();
      check(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
      check(e.val == val, {e.tag, " value"}, val, e.val);
    end
  endtask

  // Scoreboard monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_byte_vld || rx_eop || rx_overflow || rx_sync_err) begin
        check($countones({rx_byte_vld, rx_eop, rx_overflow, rx_sync_err}) == 1,
              "R12 single event", $countones({rx_byte_vld, rx_eop, rx_overflow, rx_sync_err}), 1);
      end
      if (rx_byte_vld) got_ev(EV_BYTE, int'(rx_byte));
      if (rx_eop)      got_ev(EV_EOP, int'(rx_count));
      if (rx_overflow) got_ev(EV_OVF, 0);
      if (rx_sync_err) got_ev(EV_SERR, 0);
    end
  end

  task automatic put(input int lv);
    int dur;
    dur = CPB;
    if (stretch_every != 0 && (bitno % stretch_every) == stretch_every - 1) dur = CPB + stretch_delta;
    bitno++;
    line_dp = (lv == LV_K);
    line_dm = (lv == LV_J);
    repeat (dur) @(negedge clk);
  endtask

  task automatic send_pkt(input int extra_pairs, input int tail_bits, input string tag);
    int cur;
    int ones;
    int n;
    n = pkt.size();
    for (int i = 0; i < n && i < BUF; i++) expect_ev(EV_BYTE, int'(pkt[i]), tag);
    if (n > BUF) expect_ev(EV_OVF, 0, tag);
    else         expect_ev(EV_EOP, n, tag);
    for (int i = 0; i < extra_pairs; i++) begin
      put(LV_K);
      put(LV_J);
    end
    for (int i = 0; i < 3; i++) begin
      put(LV_K);
      put(LV_J);
    end
    put(LV_K);
    put(LV_K);
    cur  = LV_K;
    ones = 1;
    for (int i = 0; i < n + 1; i++) begin
      for (int b = 0; b < 8; b++) begin
        bit v;
        if (i == n && b >= tail_bits) break;
        v = (i == n) ? bit'(b % 2 == 0) : pkt[i][b];
        if (!v) cur = (cur == LV_K) ? LV_J : LV_K;
        put(cur);
        if (v) ones++;
        else   ones = 0;
        if (ones == 6) begin
          cur = (cur == LV_K) ? LV_J : LV_K;
          put(cur);
          ones = 0;
        end
      end
    end
    put(LV_SE0);
    put(LV_SE0);
    for (int i = 0; i < 5; i++) put(LV_J);
    check(expq.size() == 0, {tag, " all events seen"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    checks = 0;
    errors = 0;
    stretch_every = 0;
    stretch_delta = 0;
    bitno = 0;
    done = 1'b0;
    line_dp = 1'b0;
    line_dm = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!rx_byte_vld && !rx_eop && !rx_overflow && !rx_sync_err, "R11 outputs low in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rx_byte_vld && !rx_eop && !rx_overflow && !rx_sync_err && rx_count == '0 && rx_byte == '0,
          "R11 outputs low after reset", int'(rx_byte), 0);
    repeat (30) @(negedge clk);
    check(!rx_byte_vld && !rx_eop && !rx_sync_err, "R1 idle J stays quiet", int'(rx_eop), 0);

    pkt = {8'hA5};
    send_pkt(0, 0, "R1 R2 R6 R8 R9 one byte");

    pkt = {8'h3C, 8'h81, 8'h00};
    send_pkt(0, 0, "R6 R8 mixed bytes");

    pkt = {8'hFF, 8'hFF, 8'h7E};
    send_pkt(0, 0, "R7 stuffing across bytes");

    pkt = {8'h1F, 8'hFC};
    send_pkt(0, 0, "R7 run counts sync bit");

    pkt = {8'h5A, 8'hC3};
    send_pkt(2, 0, "R3 extra preamble pairs");

    pkt = {};
    send_pkt(0, 0, "R9 empty packet");

    pkt = {8'h96, 8'h0F};
    send_pkt(0, 5, "R9 partial byte dropped");

    pkt = {8'h11, 8'h22, 8'h33, 8'h44};
    send_pkt(0, 0, "R10 exactly buffer size");

    pkt = {8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h77, 8'h88};
    send_pkt(0, 0, "R10 overflow");

    pkt = {8'h42};
    send_pkt(0, 0, "R10 recovery after overflow");

    stretch_every = 9;
    stretch_delta = 1;
    bitno = 0;
    pkt = {8'hFF, 8'hFF, 8'hFF, 8'h00};
    send_pkt(0, 0, "R5 slow bit clock");

    stretch_delta = -1;
    bitno = 0;
    pkt = {8'hFF, 8'hFF, 8'hFF, 8'h00};
    send_pkt(0, 0, "R5 fast bit clock");
    stretch_every = 0;

    // Lone K pulse: hunt must time out
    expect_ev(EV_SERR, 0, "R4 sync timeout");
    put(LV_K);
    for (int i = 0; i < 6; i++) put(LV_J);
    check(expq.size() == 0, "R4 timeout reported", expq.size(), 0);
    expq.delete();

    pkt = {8'h69};
    send_pkt(0, 0, "R4 receive after timeout");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule